// File: doc/BRIEF.md
# Partitioned SIMD Logical Shifter

This block is a purely combinational logical shifter for a 16-bit operand. A run-time partition mask splits the operand into one 16-bit lane, two 8-bit lanes or four 4-bit lanes. Every lane shifts on its own, and no bit ever crosses from one active lane into its neighbour. Shifts go left or right. Positions that are vacated fill with zero, and bits pushed past a lane edge are lost.

The shift amount comes from one of two places. In per-lane mode, each lane reads its amount from the bits of B that start at that lane's least significant bit. In broadcast mode, the low nibble of B gives a single amount that every lane uses. In both modes the amount is reduced modulo the lane width. The block suits a SIMD integer datapath where the element size is chosen per instruction and there is no pipeline register around the shifter.

Top module: `simd_lane_shifter`

## Requirements
- R1: When `part_mask[1]` is 0, the operand is one 16-bit lane, and `part_mask[0]` and `part_mask[2]` have no effect on the result.
- R2: When `part_mask` is 3'b111, the operand is four 4-bit lanes, at bits [3:0], [7:4], [11:8] and [15:12].
- R3: When `part_mask[1]` is 1 and `part_mask` is not 3'b111, the operand is two 8-bit lanes, at bits [7:0] and [15:8].
- R4: With `dir_right` = 0, each lane shifts toward its MSB. Bits that leave the lane top are lost, none enters the next lane, and vacated LSB positions are 0.
- R5: With `dir_right` = 1, each lane shifts toward its LSB. Bits that leave the lane bottom are lost, none enters the lane below, and vacated MSB positions are 0.
- R6: With `bcast` = 0 (per-lane mode), a lane's amount is the 4 bits of B starting at that lane's least significant bit position.
- R7: With `bcast` = 1 (broadcast mode), B[3:0] is the amount for every lane, and B[15:4] has no effect.
- R8: The amount used is the selected 4-bit value ANDed with lane width minus 1: 4 bits for 16-bit lanes, 3 bits for 8-bit lanes, 2 bits for 4-bit lanes.
- R9: A lane whose masked amount is 0 passes A through unchanged.
- R10: The block holds no state. `y` follows the inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | Operand to be shifted |
| b | input | 16 | Shift amounts: one field per lane, or the low nibble in broadcast mode |
| part_mask | input | 3 | Lane boundary select: 000 gives one lane, x1x gives two lanes, 111 gives four lanes |
| dir_right | input | 1 | Direction: 0 shifts left, 1 shifts right |
| bcast | input | 1 | Amount source: 0 per-lane, 1 broadcast from B[3:0] |
| y | output | 16 | Shifted result |

## Verification
Hand-picked operands test each lane layout on its own terms. Patterns with a set bit at a lane edge show whether a shifted bit leaks into the next lane or is properly dropped. Amounts at or above the lane width separate correct masking from a raw amount. B values with junk in the upper bits separate broadcast mode from per-lane mode. Mask values that set only the outer bits show whether those bits are correctly ignored. Several hundred random vectors, spread over every mask value, direction and mode, are then compared with a behavioural per-lane model. One check samples the output shortly after the inputs change, within the same cycle.

// File: rtl/simd_shf_pkg.sv
package simd_shf_pkg;

  // true when bit positions i and j fall in the same lane of width 2**lg
  function automatic logic same_lane(input int i, input int j, input int lg);
    return (i >> lg) == (j >> lg);
  endfunction

  // granule index of the first granule of the lane holding granule g
  function automatic int lane_base(input int g, input int glog);
    return (g >> glog) << glog;
  endfunction

endpackage

// File: rtl/shf_lane_decode.sv
module shf_lane_decode #(
  parameter int GW  = 4,
  parameter int NG  = 4,
  parameter int LGW = 3
) (
  input  logic [NG-2:0]  part_mask,
  output logic [LGW-1:0] lane_lg
);
  localparam int DW = GW * NG;
  localparam int GL = $clog2(GW);
  localparam int FL = $clog2(DW);

  always_comb begin
    if (&part_mask)                lane_lg = LGW'(GL);
    else if (part_mask[NG/2-1])    lane_lg = LGW'(FL - 1);
    else                           lane_lg = LGW'(FL);
  end
endmodule

// File: rtl/shf_amt_route.sv
module shf_amt_route
  import simd_shf_pkg::*;
#(
  parameter int GW  = 4,
  parameter int NG  = 4,
  parameter int AW  = 4,
  parameter int LGW = 3
) (
  input  logic [GW*NG-1:0] b,
  input  logic             bcast,
  input  logic [LGW-1:0]   lane_lg,
  output logic [NG*AW-1:0] gran_amt
);
  localparam int GL = $clog2(GW);

  logic [AW-1:0] lim;
  assign lim = AW'((1 << lane_lg) - 1);

  always_comb begin
    gran_amt = '0;
    for (int g = 0; g < NG; g++) begin
      int base;
      logic [AW-1:0] raw;
      base = lane_base(g, int'(lane_lg) - GL);
      raw  = bcast ? b[AW-1:0] : b[base*GW +: AW];
      gran_amt[g*AW +: AW] = raw & lim;
    end
  end
endmodule

// File: rtl/shf_stage.sv
module shf_stage
  import simd_shf_pkg::*;
#(
  parameter int GW   = 4,
  parameter int NG   = 4,
  parameter int STEP = 1,
  parameter int LGW  = 3
) (
  input  logic [GW*NG-1:0] din,
  input  logic [NG-1:0]    gran_en,
  input  logic [LGW-1:0]   lane_lg,
  input  logic             dir_right,
  output logic [GW*NG-1:0] dout
);
  localparam int DW = GW * NG;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    logic from_lo, from_hi;
    if (i >= STEP) begin : g_lo
      assign from_lo = same_lane(i, i - STEP, int'(lane_lg)) ? din[i-STEP] : 1'b0;
    end else begin : g_lo_edge
      assign from_lo = 1'b0;
    end
    if (i + STEP < DW) begin : g_hi
      assign from_hi = same_lane(i, i + STEP, int'(lane_lg)) ? din[i+STEP] : 1'b0;
    end else begin : g_hi_edge
      assign from_hi = 1'b0;
    end
    assign dout[i] = gran_en[i/GW] ? (dir_right ? from_hi : from_lo) : din[i];
  end
endmodule

// File: rtl/simd_lane_shifter.sv
module simd_lane_shifter #(
  parameter int GW = 4,
  parameter int NG = 4
) (
  input  logic [GW*NG-1:0] a,
  input  logic [GW*NG-1:0] b,
  input  logic [NG-2:0]    part_mask,
  input  logic             dir_right,
  input  logic             bcast,
  output logic [GW*NG-1:0] y
);
  localparam int DW  = GW * NG;
  localparam int AW  = $clog2(DW);
  localparam int NS  = AW;
  localparam int LGW = $clog2(AW + 1);

  logic [LGW-1:0]   lane_lg;
  logic [NG*AW-1:0] gran_amt;
  logic [DW-1:0]    stage_d [NS+1];
  logic [NG-1:0]    stage_en [NS];

  shf_lane_decode #(.GW(GW), .NG(NG), .LGW(LGW)) u_decode (
    .part_mask (part_mask),
    .lane_lg   (lane_lg)
  );

  shf_amt_route #(.GW(GW), .NG(NG), .AW(AW), .LGW(LGW)) u_route (
    .b        (b),
    .bcast    (bcast),
    .lane_lg  (lane_lg),
    .gran_amt (gran_amt)
  );

  assign stage_d[0] = a;

  for (genvar s = 0; s < NS; s++) begin : g_stage
    for (genvar g = 0; g < NG; g++) begin : g_en
      assign stage_en[s][g] = gran_amt[g*AW + s];
    end
    shf_stage #(.GW(GW), .NG(NG), .STEP(1 << s), .LGW(LGW)) u_stage (
      .din       (stage_d[s]),
      .gran_en   (stage_en[s]),
      .lane_lg   (lane_lg),
      .dir_right (dir_right),
      .dout      (stage_d[s+1])
    );
  end

  assign y = stage_d[NS];
endmodule

// File: rtl/simd_lane_shifter_chk.sv
module simd_lane_shifter_chk #(
  parameter int GW  = 4,
  parameter int NG  = 4,
  parameter int AW  = 4,
  parameter int LGW = 3
) (
  input logic [GW*NG-1:0] a,
  input logic [GW*NG-1:0] y,
  input logic             dir_right,
  input logic             bcast,
  input logic [LGW-1:0]   lane_lg,
  input logic [NG*AW-1:0] gran_amt
);
  localparam int GL = $clog2(GW);

  always_comb begin
    for (int g = 0; g < NG; g++) begin
      int gpl;
      int base;
      logic [AW-1:0] amt;
      logic [AW-1:0] bamt;
      gpl  = 1 << (int'(lane_lg) - GL);
      base = (g / gpl) * gpl;
      amt  = gran_amt[g*AW +: AW];
      bamt = gran_amt[base*AW +: AW];
      // R8: amount never reaches the lane width
      p_amt_below_width_r8: assert (int'(amt) < (1 << lane_lg));
      // R7: broadcast gives every granule the same amount
      p_bcast_uniform_r7: assert (!bcast || amt == gran_amt[AW-1:0]);
      // R6: granules of one lane share the lane-base amount
      p_lane_shares_amt_r6: assert (bcast || amt == bamt);
      // R9: zero amount keeps the data
      p_zero_amt_pass_r9: assert (amt != '0 || y[g*GW +: GW] == a[g*GW +: GW]);
      // R4: left shift zero-fills the lane bottom
      p_left_fill_r4: assert (dir_right || amt == '0 || (g % gpl) != 0 || y[g*GW] == 1'b0);
      // R5: right shift zero-fills the lane top
      p_right_fill_r5: assert (!dir_right || amt == '0 || ((g + 1) % gpl) != 0
                               || y[g*GW + GW - 1] == 1'b0);
    end
  end
endmodule

bind simd_lane_shifter simd_lane_shifter_chk #(.GW(GW), .NG(NG), .AW(AW), .LGW(LGW)) u_chk (
  .a         (a),
  .y         (y),
  .dir_right (dir_right),
  .bcast     (bcast),
  .lane_lg   (lane_lg),
  .gran_amt  (gran_amt)
);

// File: tb/simd_lane_shifter_bench.sv
module simd_lane_shifter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] a = '0, b = '0, y;
  logic [2:0]  pm = '0;
  logic        dr = 1'b0, bc = 1'b0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  simd_lane_shifter u_simd_lane_shifter (
    .a(a), .b(b), .part_mask(pm), .dir_right(dr), .bcast(bc), .y(y)
  );

  function automatic logic [15:0] model(input logic [15:0] va, input logic [15:0] vb,
                                        input logic [2:0] m, input logic d, input logic s);
    int ls, yv;
    ls = (m == 3'b111) ? 4 : (m[1] ? 8 : 16);
    yv = 0;
    for (int l = 0; l < 16; l += ls) begin
      int lm, av, amt, r;
      lm  = (1 << ls) - 1;
      av  = (int'(va) >> l) & lm;
      amt = s ? (int'(vb) & 15) : ((int'(vb) >> l) & 15);
      amt = amt % ls;
      r   = d ? (av >> amt) : ((av << amt) & lm);
      yv |= r << l;
    end
    return yv[15:0];
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: y=%h expected=%h (a=%h b=%h mask=%b dir=%b bcast=%b)",
               tag, act, exp, a, b, pm, dr, bc);
    end
  endtask

  task automatic run(input string tag, input logic [15:0] va, input logic [15:0] vb,
                     input logic [2:0] m, input logic d, input logic s, input logic [15:0] exp);
    @(posedge clk); #1;
    a = va; b = vb; pm = m; dr = d; bc = s;
    @(negedge clk);
    chk(tag, y, exp);
    chk({tag, " model"}, y, model(va, vb, m, d, s));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R10: watchdog expired, y=%h expected=settled", y);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 idle zero", y, 16'h0000);
    rst_n = 1'b1;
    run("R1 R4 R7 left bcast",            16'h1234, 16'h0004, 3'b000, 0, 1, 16'h2340);
    run("R1 outer mask bits ignored",     16'h1234, 16'h0004, 3'b101, 0, 1, 16'h2340);
    run("R3 R5 R6 right per-lane",        16'hF0F0, 16'h0302, 3'b010, 1, 0, 16'h1E3C);
    run("R2 R4 R6 left per-nibble",       16'hFFFF, 16'h3210, 3'b111, 0, 0, 16'h8CEF);
    run("R8 4-bit lane masks 5 to 1",     16'h1111, 16'h0005, 3'b111, 0, 1, 16'h2222);
    run("R8 8-bit lane masks 11 to 3",    16'h8080, 16'h000B, 3'b010, 1, 1, 16'h1010);
    run("R8 16-bit lane masks 0x11 to 1", 16'h8001, 16'h0011, 3'b000, 1, 0, 16'h4000);
    run("R7 R9 bcast upper B ignored",    16'hABCD, 16'hFFF0, 3'b111, 0, 1, 16'hABCD);
    run("R9 zero amount passes",          16'h5A5A, 16'h0000, 3'b010, 1, 0, 16'h5A5A);
    run("R4 R3 no carry into upper lane", 16'h0303, 16'h0707, 3'b011, 0, 0, 16'h8080);
    run("R5 R2 no borrow from upper",     16'h1111, 16'h1111, 3'b111, 1, 0, 16'h0000);
    run("R3 mask 110 two lanes",          16'h00FF, 16'h0004, 3'b110, 0, 1, 16'h00F0);
    // R10: same-cycle response to an input change
    @(posedge clk); #1;
    a = 16'h00FF; b = 16'h0008; pm = 3'b000; dr = 0; bc = 1;
    #1;
    chk("R10 same-cycle response", y, 16'hFF00);
    for (int n = 0; n < 600; n++) begin
      logic [15:0] ra, rb;
      logic [2:0]  rm;
      logic        rd, rs;
      string       tg;
      ra = 16'($urandom); rb = 16'($urandom);
      rm = 3'($urandom); rd = 1'($urandom); rs = 1'($urandom);
      tg = (rm == 3'b111) ? "R2 R8 random" : (rm[1] ? "R3 R8 random" : "R1 R8 random");
      @(posedge clk); #1;
      a = ra; b = rb; pm = rm; dr = rd; bc = rs;
      @(negedge clk);
      chk(tg, y, model(ra, rb, rm, rd, rs));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule